// File: doc/BRIEF.md
# Serial Transceiver with Receiver Mute and Wakeup

This block is a full-duplex asynchronous serial port for a shared multi-drop line. A transmitter and a receiver run at the same time and are switched on separately. Both use one programmable baud divider that produces a 16x oversampling tick. Each frame carries a start bit, eight payload bits sent LSB first, and one stop bit. When parity is on, the top payload bit carries an even or odd parity bit.

A node can put its receiver into a mute state when traffic is meant for another node. While muted, the receiver still follows the frames on the line, but it throws them away: no data is delivered and no error flag is raised. One of two configurable conditions ends the mute state. The first is a whole frame time of continuous mark (idle line). The second is a frame whose address-mark bit is set; that frame is then delivered as data. Software reaches the block through a small write port that holds the transmit data, the divisor and the control fields. Received bytes are read through a data output with a valid flag and a read strobe.

Top module: `uart_mute_top`

## Requirements
- R1: After reset, txd is 1, tx_busy, rx_valid, all error flags, muted and irq are 0. The divisor resets to 16 and both directions are disabled.
- R2: A write to address 0 with the transmitter enabled sends one frame: a start bit of 0, eight payload bits LSB first, and a stop bit of 1. txd falls on the clock after the write.
- R3: While the transmitter enable (control bit 0) is 0, txd stays 1, tx_busy stays 0 and writes to address 0 are dropped.
- R4: With the receiver enable (control bit 1) set, a frame on rxd sets rx_valid and shows the payload on rx_data. A one-cycle rx_rd pulse clears rx_valid. With the receiver disabled, frames are ignored.
- R5: Control bit 2 turns parity on and control bit 3 selects odd parity. The transmitter replaces payload bit 7 with the parity of bits 6..0. The receiver delivers all eight bits and sets err_parity when the count of ones over those eight bits does not match the selected parity.
- R6: A stop bit sampled at 0 sets err_frame. The byte is still delivered, and a new start bit is accepted only after the line has returned to 1.
- R7: When a frame completes while rx_valid is still set, err_overrun is set and rx_data keeps the unread byte.
- R8: Writing control with bit 5 set enters mute. While muted, completed frames set neither rx_valid nor any error flag.
- R9: With wake mode 0 (control bit 4 = 0), a continuous mark of 10 bit times clears mute. With wake mode 1, idle does not clear mute. In mode 1, a frame whose address bit is 0 is discarded, and a frame whose address bit is 1 clears mute and is delivered. The address bit is payload bit 7, or payload bit 6 when parity is on.
- R10: irq is 1 exactly when rx_valid or any error flag is set. rx_rd clears all error flags.
- R11: One bit lasts 16 x max(floor(divisor/16), 1) clock cycles. The divisor is written at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 transmit data, 1 divisor, 2 control |
| reg_wdata | input | 16 | Write data |
| rx_rd | input | 1 | Read strobe; takes the received byte and clears error flags |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_busy | output | 1 | A frame is being sent |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | rx_data holds an unread byte |
| err_parity | output | 1 | Parity mismatch seen |
| err_frame | output | 1 | Stop bit sampled low |
| err_overrun | output | 1 | Byte lost because the previous one was unread |
| muted | output | 1 | Receiver is in mute state |
| irq | output | 1 | Data or error pending |

## Verification
All 256 byte values are sent with txd looped back to rxd. Each frame is checked bit by bit on the line and again as a received byte, which separates bit-order and shift errors from receiver sampling errors. A stepped sweep of payloads under even and then odd parity separates the parity polarity, the choice of bit position and the receive check. Hand-built frames with bad parity, a low stop bit, back-to-back unread bytes and address bits of 0 and 1 under both wake modes separate the discard path from the delivery path. High-bit runs measured at two divisors, one of them below 16, pin down the bit length.

// File: rtl/uart_mute_pkg.sv
package uart_mute_pkg;
    localparam int OVS       = 16;
    localparam int DATA_BITS = 8;
    localparam int DIV_W     = 16;
    localparam int FRAME_BITS = DATA_BITS + 2;

    typedef struct packed {
        logic wake_addr;
        logic par_odd;
        logic par_en;
        logic rx_en;
        logic tx_en;
    } cfg_t;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 ferr;
        logic                 perr;
    } rx_frame_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK
    } rx_state_e;

    function automatic logic [DATA_BITS-1:0] tx_word(
        input logic [DATA_BITS-1:0] d, input logic par_en, input logic par_odd);
        logic [DATA_BITS-1:0] w;
        w = d;
        if (par_en) w[DATA_BITS-1] = (^d[DATA_BITS-2:0]) ^ par_odd;
        return w;
    endfunction
endpackage

// File: rtl/uart_mute_baud.sv
module uart_mute_baud
    import uart_mute_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int OS = OVS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] div,
    output logic          tick
);
    localparam int OW = $clog2(OS);
    localparam int CW = DW - OW;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim = (div[DW-1:OW] == '0) ? CW'(1) : div[DW-1:OW];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim - CW'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CW'(1);
            tick <= 1'b0;
        end
    end

    // R11: the smallest divisor gives one oversampling tick per clock
    assert_tick_every_clock_R11: assert property (@(posedge clk) disable iff (rst)
        (lim == CW'(1)) |=> tick);
endmodule

// File: rtl/uart_mute_tx.sv
module uart_mute_tx
    import uart_mute_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 enable,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_data,
    output logic                 txd,
    output logic                 busy
);
    localparam int TW = $clog2(OVS);
    localparam int BW = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] shreg;
    logic [TW-1:0]         tcnt;
    logic [BW-1:0]         bcnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            busy  <= 1'b0;
            shreg <= '1;
            tcnt  <= '0;
            bcnt  <= '0;
        end else if (load && !busy) begin
            shreg <= {1'b1, tx_word(load_data, par_en, par_odd), 1'b0};
            busy  <= 1'b1;
            tcnt  <= '0;
            bcnt  <= '0;
        end else if (busy && tick) begin
            if (tcnt == TW'(OVS - 1)) begin
                tcnt  <= '0;
                shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                if (bcnt == BW'(FRAME_BITS - 1)) busy <= 1'b0;
                else bcnt <= bcnt + BW'(1);
            end else begin
                tcnt <= tcnt + TW'(1);
            end
        end
    end

    assign txd = busy ? shreg[0] : 1'b1;

    // R3: a disabled transmitter holds the line at mark
    assert_tx_disabled_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (txd && !busy));
    // R2: an accepted load drives the start bit on the next clock
    assert_tx_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        (enable && load && !busy) |=> (!txd && busy));
endmodule

// File: rtl/uart_mute_rx.sv
module uart_mute_rx
    import uart_mute_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      enable,
    input  logic      par_en,
    input  logic      par_odd,
    input  logic      idle_clr,
    input  logic      rxd,
    output logic      done,
    output rx_frame_t frame,
    output logic      idle_evt
);
    localparam int TW = $clog2(OVS);
    localparam int BW = $clog2(DATA_BITS);
    localparam int IDLE_TICKS = OVS * FRAME_BITS;
    localparam int IW = $clog2(IDLE_TICKS + 1);

    logic                 rx_m, rx_s;
    rx_state_e            st;
    logic [TW-1:0]        tcnt;
    logic [BW-1:0]        bcnt;
    logic [DATA_BITS-1:0] sreg;
    logic [IW-1:0]        idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
        end
    end

    always_ff @(posedge clk) begin
        done     <= 1'b0;
        idle_evt <= 1'b0;
        if (rst || !enable) begin
            st       <= RX_IDLE;
            tcnt     <= '0;
            bcnt     <= '0;
            sreg     <= '0;
            frame    <= '0;
            idle_cnt <= '0;
        end else begin
            if (tick) begin
                case (st)
                    RX_IDLE: if (!rx_s) begin
                        st   <= RX_START;
                        tcnt <= '0;
                    end
                    RX_START: begin
                        if (tcnt == TW'(OVS / 2 - 1)) begin
                            st   <= rx_s ? RX_IDLE : RX_DATA;
                            tcnt <= '0;
                            bcnt <= '0;
                        end else tcnt <= tcnt + TW'(1);
                    end
                    RX_DATA: begin
                        if (tcnt == TW'(OVS - 1)) begin
                            tcnt <= '0;
                            sreg <= {rx_s, sreg[DATA_BITS-1:1]};
                            if (bcnt == BW'(DATA_BITS - 1)) st <= RX_STOP;
                            else bcnt <= bcnt + BW'(1);
                        end else tcnt <= tcnt + TW'(1);
                    end
                    RX_STOP: begin
                        if (tcnt == TW'(OVS - 1)) begin
                            tcnt       <= '0;
                            done       <= 1'b1;
                            frame.data <= sreg;
                            frame.ferr <= !rx_s;
                            frame.perr <= par_en && ((^sreg) != par_odd);
                            st         <= rx_s ? RX_IDLE : RX_BREAK;
                        end else tcnt <= tcnt + TW'(1);
                    end
                    RX_BREAK: if (rx_s) st <= RX_IDLE;
                    default: st <= RX_IDLE;
                endcase
            end
            if (idle_clr || !rx_s || st != RX_IDLE) begin
                idle_cnt <= '0;
            end else if (tick && idle_cnt != IW'(IDLE_TICKS)) begin
                idle_cnt <= idle_cnt + IW'(1);
                if (idle_cnt == IW'(IDLE_TICKS - 1)) idle_evt <= 1'b1;
            end
        end
    end

    // R6: after a low stop bit no new frame starts while the line is still low
    assert_break_waits_high_R6: assert property (@(posedge clk) disable iff (rst)
        (st == RX_BREAK && !rx_s) |=> (st != RX_START));
endmodule

// File: rtl/uart_mute_top.sv
module uart_mute_top
    import uart_mute_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    input  logic        rx_rd,
    input  logic        rxd,
    output logic        txd,
    output logic        tx_busy,
    output logic [7:0]  rx_data,
    output logic        rx_valid,
    output logic        err_parity,
    output logic        err_frame,
    output logic        err_overrun,
    output logic        muted,
    output logic        irq
);
    localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(16);

    cfg_t             cfg;
    logic [DIV_W-1:0] div;
    logic             tick;
    logic             tx_load;
    logic             mute_req;
    logic             rx_done;
    rx_frame_t        rx_frame;
    logic             idle_evt;
    logic             addr_bit;
    logic             deliver;

    assign tx_load  = reg_wr && reg_addr == 2'd0;
    assign mute_req = reg_wr && reg_addr == 2'd2 && reg_wdata[5];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            div <= DIV_RESET;
        end else if (reg_wr) begin
            if (reg_addr == 2'd1) div <= reg_wdata[DIV_W-1:0];
            if (reg_addr == 2'd2) cfg <= cfg_t'(reg_wdata[4:0]);
        end
    end

    uart_mute_baud u_baud (.clk(clk), .rst(rst), .div(div), .tick(tick));

    uart_mute_tx u_tx (
        .clk(clk), .rst(rst), .tick(tick), .enable(cfg.tx_en),
        .par_en(cfg.par_en), .par_odd(cfg.par_odd),
        .load(tx_load), .load_data(reg_wdata[DATA_BITS-1:0]),
        .txd(txd), .busy(tx_busy)
    );

    uart_mute_rx u_rx (
        .clk(clk), .rst(rst), .tick(tick), .enable(cfg.rx_en),
        .par_en(cfg.par_en), .par_odd(cfg.par_odd), .idle_clr(mute_req),
        .rxd(rxd), .done(rx_done), .frame(rx_frame), .idle_evt(idle_evt)
    );

    assign addr_bit = cfg.par_en ? rx_frame.data[DATA_BITS-2] : rx_frame.data[DATA_BITS-1];
    assign deliver  = rx_done && (!muted || (cfg.wake_addr && addr_bit));

    always_ff @(posedge clk) begin
        if (rst) begin
            muted <= 1'b0;
        end else if (mute_req) begin
            muted <= 1'b1;
        end else if (muted && !cfg.wake_addr && idle_evt) begin
            muted <= 1'b0;
        end else if (muted && cfg.wake_addr && rx_done && addr_bit) begin
            muted <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid    <= 1'b0;
            rx_data     <= '0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            err_parity  <= (err_parity && !rx_rd) || (deliver && cfg.par_en && rx_frame.perr);
            err_frame   <= (err_frame && !rx_rd) || (deliver && rx_frame.ferr);
            err_overrun <= (err_overrun && !rx_rd) || (deliver && rx_valid && !rx_rd);
            if (deliver && !(rx_valid && !rx_rd)) begin
                rx_valid <= 1'b1;
                rx_data  <= rx_frame.data;
            end else if (rx_rd) begin
                rx_valid <= 1'b0;
            end
        end
    end

    assign irq = rx_valid || err_parity || err_frame || err_overrun;

    // R8: in idle-wake mute, no byte is handed over
    assert_mute_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (muted && !cfg.wake_addr) |=> !$rose(rx_valid));
    // R7: an unread byte is never overwritten
    assert_unread_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_rd) |=> $stable(rx_data));
    // R5: parity errors only arise with parity enabled
    assert_parity_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(err_parity) |-> $past(cfg.par_en));
endmodule

// File: tb/uart_mute_top_tb_top.sv
`timescale 1ns/1ps
module uart_mute_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        rx_rd = 1'b0;
    logic        drv_rxd = 1'b1;
    logic        loop = 1'b0;
    logic        rxd;
    logic        txd, tx_busy, rx_valid, err_parity, err_frame, err_overrun, muted, irq;
    logic [7:0]  rx_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    assign rxd = loop ? txd : drv_rxd;

    uart_mute_top dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rx_rd(rx_rd), .rxd(rxd), .txd(txd), .tx_busy(tx_busy), .rx_data(rx_data),
        .rx_valid(rx_valid), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .muted(muted), .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 195000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<195000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rx(output bit got);
        got = 1'b0;
        for (int i = 0; i < 2000 && !got; i++) begin
            @(negedge clk);
            if (rx_valid) got = 1'b1;
        end
    endtask

    task automatic wait_tx_idle();
        for (int i = 0; i < 4000 && tx_busy; i++) @(negedge clk);
    endtask

    // capture one frame from txd, sampling mid-bit
    task automatic grab_tx(input int bt, output logic [9:0] got);
        got = '0;
        for (int i = 0; i < 4000 && txd; i++) @(negedge clk);
        repeat (bt / 2) @(negedge clk);
        got[0] = txd;
        for (int b = 1; b < 10; b++) begin
            repeat (bt) @(negedge clk);
            got[b] = txd;
        end
    endtask

    task automatic send_rx(input logic [7:0] d, input logic stop_bit);
        @(negedge clk);
        drv_rxd = 1'b0; idle(16);
        for (int b = 0; b < 8; b++) begin
            drv_rxd = d[b]; idle(16);
        end
        drv_rxd = stop_bit; idle(16);
        drv_rxd = 1'b1; idle(32);
    endtask

    task automatic high_run(output int n);
        n = 0;
        for (int i = 0; i < 4000 && txd; i++) @(negedge clk);
        for (int i = 0; i < 4000 && !txd; i++) @(negedge clk);
        for (int i = 0; i < 4000 && txd; i++) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [9:0] fr;
        logic [7:0] w;
        bit got;
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1 && !tx_busy, "R1 txd/tx_busy", {txd, tx_busy}, 2'b10);
        chk(!rx_valid && !err_parity && !err_frame && !err_overrun, "R1 flags",
            {rx_valid, err_parity, err_frame, err_overrun}, 0);
        chk(!muted && !irq, "R1 muted/irq", {muted, irq}, 0);

        // R2 R4: every byte value in loopback
        loop = 1'b1;
        wr(2, 16'h0003);
        for (int v = 0; v < 256; v++) begin
            wr(0, 16'(v));
            grab_tx(16, fr);
            chk(fr == {1'b1, 8'(v), 1'b0}, "R2 tx frame", fr, {1'b1, 8'(v), 1'b0});
            wait_rx(got);
            chk(got && rx_data == 8'(v) && !irq == 1'b0 && !err_frame && !err_parity,
                "R4 rx byte", rx_data, v);
            rd_pulse();
            chk(!rx_valid, "R4 rx_rd clears rx_valid", rx_valid, 0);
            wait_tx_idle();
        end

        // R5: even then odd parity
        for (int odd = 0; odd < 2; odd++) begin
            wr(2, odd ? 16'h000F : 16'h0007);
            for (int v = 0; v < 256; v += 11) begin
                w = 8'(v);
                w[7] = (^w[6:0]) ^ odd[0];
                wr(0, 16'(v));
                grab_tx(16, fr);
                chk(fr == {1'b1, w, 1'b0}, "R5 tx parity bit", fr, {1'b1, w, 1'b0});
                wait_rx(got);
                chk(got && rx_data == w && !err_parity, "R5 rx parity ok", rx_data, w);
                rd_pulse();
                wait_tx_idle();
            end
        end

        // R5 R10: parity mismatch
        loop = 1'b0;
        wr(2, 16'h0007);
        send_rx(8'h01, 1'b1);
        wait_rx(got);
        chk(got && err_parity && rx_data == 8'h01, "R5 parity error flagged", {err_parity, rx_data}, 9'h101);
        chk(irq, "R10 irq with error", irq, 1);
        rd_pulse();
        chk(!err_parity && !irq, "R10 rx_rd clears errors", {err_parity, irq}, 0);

        // R6 framing
        wr(2, 16'h0003);
        send_rx(8'h3C, 1'b0);
        wait_rx(got);
        chk(got && err_frame && rx_data == 8'h3C, "R6 framing error", {err_frame, rx_data}, 9'h13C);
        idle(200);
        chk(!err_overrun, "R6 no false frame after low stop", err_overrun, 0);
        rd_pulse();

        // R7 overrun
        send_rx(8'h11, 1'b1);
        send_rx(8'h22, 1'b1);
        chk(err_overrun && rx_data == 8'h11 && rx_valid, "R7 overrun keeps old byte",
            {err_overrun, rx_data}, 9'h111);
        rd_pulse();
        chk(!err_overrun && !irq, "R7 overrun cleared", {err_overrun, irq}, 0);

        // R4 receiver disabled
        wr(2, 16'h0001);
        send_rx(8'h55, 1'b1);
        chk(!rx_valid, "R4 disabled receiver ignores", rx_valid, 0);

        // R3 transmitter disabled
        wr(2, 16'h0002);
        wr(0, 16'h0000);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!txd || tx_busy) n++;
        end
        chk(n == 0, "R3 disabled transmitter idle", n, 0);

        // R8 R9: idle-line wake
        wr(2, 16'h0023);
        send_rx(8'h41, 1'b1);
        send_rx(8'h42, 1'b0);
        chk(!rx_valid && !err_frame && !err_parity && !err_overrun, "R8 muted frames discarded",
            {rx_valid, err_frame, err_parity, err_overrun}, 0);
        chk(muted, "R9 still muted between frames", muted, 1);
        idle(200);
        chk(!muted, "R9 idle line clears mute", muted, 0);
        send_rx(8'h43, 1'b1);
        chk(rx_valid && rx_data == 8'h43, "R9 delivery after idle wake", rx_data, 8'h43);
        rd_pulse();

        // R9: address-mark wake
        wr(2, 16'h0033);
        send_rx(8'h35, 1'b1);
        chk(!rx_valid && muted, "R9 address bit 0 discarded", {rx_valid, muted}, 1);
        idle(300);
        chk(muted, "R9 idle ignored in address mode", muted, 1);
        send_rx(8'h9A, 1'b1);
        chk(rx_valid && rx_data == 8'h9A && !muted, "R9 address frame wakes",
            {muted, rx_data}, 8'h9A);
        rd_pulse();

        // R11 divisor
        loop = 1'b1;
        wr(2, 16'h0003);
        wr(1, 16'd48);
        wr(0, 16'h000F);
        high_run(n);
        chk(n == 4 * 48, "R11 bit time at divisor 48", n, 4 * 48);
        wait_rx(got);
        chk(got && rx_data == 8'h0F, "R11 rx at divisor 48", rx_data, 8'h0F);
        rd_pulse();
        wait_tx_idle();
        wr(1, 16'd5);
        wr(0, 16'h000F);
        high_run(n);
        chk(n == 4 * 16, "R11 divisor below 16 clamps", n, 4 * 16);
        wait_rx(got);
        rd_pulse();

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule